// File: doc/BRIEF.md
# Dual-Slot Transport Stream Router

The router carries a byte-wide parallel transport stream through two removable conditional-access slots in series and then to one output. Each beat is a bundle of four signals: a byte strobe, a payload-valid flag, a packet-start sync flag and eight data bits. The bundle is registered on entry, after each slot position and on exit. The route from input to output therefore always has the same length. Each slot position either forwards the module's returned beat or bypasses the module. Only the returned data bits pass through that slot's invert mask first.

A slot is bypassed whenever its output-enable control is clear or its card-present input is low. Bypass follows those two inputs on every clock, whatever the packet alignment, so a card pulled mid-packet never breaks the chain. A swap control reverses the order in which the two slots are visited. The swap control and the invert masks are copied into the datapath only on clocks where the input byte strobe is high.

The stream has no ready signal and cannot be stalled. The source paces bytes with `in_stb`, and every downstream consumer (the modules and the output sink) must accept one bundle per clock. The module side is treated as returning its beat in the same clock that it receives it.

Top module: `tsr_router`

## Requirements
- R1: After reset every output is zero, the swap control is cleared and both masks are zero. Until new values are loaded, a beat with `cfg_oe` = 00 leaves the output unchanged.
- R2: A bundle sampled on input at rising edge N appears on the `out_*` ports after rising edge N+3. This latency is the same for every bypass, swap and mask setting.
- R3: A slot whose `cfg_oe` bit is 0 or whose `slot_present` bit is 0 passes its chain input to the next hop unchanged.
- R4: Removing a card (`slot_present` bit falling) bypasses that slot from the next clock edge while `cfg_oe` is still set. This holds even when a beat is already in flight.
- R5: With swap 0 the stream visits slot 0 (A) and then slot 1 (B). With swap 1 it visits B and then A. The first slot is fed the registered input and the second slot is fed the registered result of the first.
- R6: Data returned by an active slot is XORed with that slot's mask before it is used. Slot s uses bits `cfg_mask[s*8+7:s*8]`. Strobe, valid and sync are not affected by the mask.
- R7: Swap and masks are loaded on a rising edge only when `in_stb` is 1. Changes made while `in_stb` is 0 have no effect on routing or data.
- R8: While a slot's `slot_present` bit is 0, all of that slot's `slot_tx_*` bits are held at zero.
- R9: Strobe, valid, sync and data of one beat stay aligned in the same clock at every hop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_stb | input | 1 | Byte strobe of the incoming stream |
| in_vld | input | 1 | Payload-valid flag of the incoming stream |
| in_sync | input | 1 | Packet-start flag of the incoming stream |
| in_data | input | 8 | Incoming stream byte |
| cfg_swap | input | 1 | 1 = visit slot B before slot A |
| cfg_oe | input | 2 | Per-slot enable of the module path (bit 0 = A) |
| cfg_mask | input | 16 | Invert masks, slot A in bits 7:0, slot B in bits 15:8 |
| slot_present | input | 2 | Card-present indication per slot |
| slot_tx_stb | output | 2 | Strobe sent to each slot |
| slot_tx_vld | output | 2 | Valid flag sent to each slot |
| slot_tx_sync | output | 2 | Sync flag sent to each slot |
| slot_tx_data | output | 16 | Byte sent to each slot, slot A in bits 7:0 |
| slot_rx_stb | input | 2 | Strobe returned by each slot |
| slot_rx_vld | input | 2 | Valid flag returned by each slot |
| slot_rx_sync | input | 2 | Sync flag returned by each slot |
| slot_rx_data | input | 16 | Byte returned by each slot, slot A in bits 7:0 |
| out_stb | output | 1 | Output byte strobe |
| out_vld | output | 1 | Output valid flag |
| out_sync | output | 1 | Output sync flag |
| out_data | output | 8 | Output byte |

## Verification
Several properties are checked on every clock:
- an absent slot sends only zeros;
- the swap setting never moves on a clock without a strobe;
- the first slot in the active order receives the previous cycle's input;
- after four all-bypass cycles, the output equals the input of four edges before.

Only the directed scenarios can show the rest:
- the exact composite transform for each visiting order;
- mask correction against a model of inverting modules;
- a mask change that arrives between strobes being ignored;
- a card pulled while its beat is already inside the pipe.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  parameter int unsigned TS_DATA_W = 8;
  // Swap ordering is defined for exactly two slots.
  parameter int unsigned TS_SLOTS  = 2;

  typedef struct packed {
    logic                 stb;
    logic                 vld;
    logic                 sync;
    logic [TS_DATA_W-1:0] data;
  } ts_beat_t;

  localparam int unsigned TS_BEAT_W = $bits(ts_beat_t);

  function automatic ts_beat_t beat_flip(ts_beat_t b, logic [TS_DATA_W-1:0] m);
    ts_beat_t r;
    r      = b;
    r.data = b.data ^ m;
    return r;
  endfunction
endpackage

// File: rtl/tsr_hop_reg.sv
module tsr_hop_reg
  import tsr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  ts_beat_t d,
  output ts_beat_t q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/tsr_cfg_shadow.sv
module tsr_cfg_shadow #(
  parameter int unsigned NS = 2,
  parameter int unsigned DW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           swap_in,
  input  logic [NS*DW-1:0] mask_in,
  output logic           swap_q,
  output logic [NS*DW-1:0] mask_q
);
  // Copies only on a byte-strobe edge so a byte never sees a half-applied change.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      swap_q <= 1'b0;
      mask_q <= '0;
    end else if (load) begin
      swap_q <= swap_in;
      mask_q <= mask_in;
    end
  end
endmodule

// File: rtl/tsr_slot_stage.sv
module tsr_slot_stage
  import tsr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  ts_beat_t             chain_in,
  input  ts_beat_t             ret_in,
  input  logic                 use_module,
  input  logic [TS_DATA_W-1:0] mask,
  output ts_beat_t             q
);
  ts_beat_t ret_fixed;
  ts_beat_t nxt;

  always_comb begin
    ret_fixed = beat_flip(ret_in, mask);
    nxt       = use_module ? ret_fixed : chain_in;
  end

  tsr_hop_reg u_hop (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (nxt),
    .q     (q)
  );
endmodule

// File: rtl/tsr_router.sv
module tsr_router
  import tsr_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_stb,
  input  logic                          in_vld,
  input  logic                          in_sync,
  input  logic [TS_DATA_W-1:0]          in_data,
  input  logic                          cfg_swap,
  input  logic [TS_SLOTS-1:0]           cfg_oe,
  input  logic [TS_SLOTS*TS_DATA_W-1:0] cfg_mask,
  input  logic [TS_SLOTS-1:0]           slot_present,
  output logic [TS_SLOTS-1:0]           slot_tx_stb,
  output logic [TS_SLOTS-1:0]           slot_tx_vld,
  output logic [TS_SLOTS-1:0]           slot_tx_sync,
  output logic [TS_SLOTS*TS_DATA_W-1:0] slot_tx_data,
  input  logic [TS_SLOTS-1:0]           slot_rx_stb,
  input  logic [TS_SLOTS-1:0]           slot_rx_vld,
  input  logic [TS_SLOTS-1:0]           slot_rx_sync,
  input  logic [TS_SLOTS*TS_DATA_W-1:0] slot_rx_data,
  output logic                          out_stb,
  output logic                          out_vld,
  output logic                          out_sync,
  output logic [TS_DATA_W-1:0]          out_data
);
  localparam int unsigned DW   = TS_DATA_W;
  localparam int unsigned NS   = TS_SLOTS;
  localparam int unsigned LAST = NS - 1;

  ts_beat_t        in_beat;
  ts_beat_t        in_q;
  ts_beat_t        out_q;
  ts_beat_t        rx_beat  [NS];
  ts_beat_t        tx_beat  [NS];
  ts_beat_t        stage_q  [NS];
  ts_beat_t        chain_in [NS];
  logic [DW-1:0]   mask_arr [NS];
  logic            swap_q;
  logic [NS*DW-1:0] mask_q;

  assign in_beat = '{stb: in_stb, vld: in_vld, sync: in_sync, data: in_data};

  tsr_cfg_shadow #(.NS(NS), .DW(DW)) u_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (in_stb),
    .swap_in (cfg_swap),
    .mask_in (cfg_mask),
    .swap_q  (swap_q),
    .mask_q  (mask_q)
  );

  tsr_hop_reg u_in_hop (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (in_beat),
    .q     (in_q)
  );

  // Physical slot side: unpack returns, feed each slot from its chain position.
  for (genvar s = 0; s < NS; s++) begin : g_slot
    logic pos_s;
    assign pos_s        = swap_q ^ 1'(s);
    assign rx_beat[s]   = '{stb:  slot_rx_stb[s],
                            vld:  slot_rx_vld[s],
                            sync: slot_rx_sync[s],
                            data: slot_rx_data[s*DW +: DW]};
    assign mask_arr[s]  = mask_q[s*DW +: DW];
    // Pins of an empty slot stay low.
    assign tx_beat[s]   = slot_present[s] ? chain_in[pos_s] : '0;
    assign slot_tx_stb[s]            = tx_beat[s].stb;
    assign slot_tx_vld[s]            = tx_beat[s].vld;
    assign slot_tx_sync[s]           = tx_beat[s].sync;
    assign slot_tx_data[s*DW +: DW]  = tx_beat[s].data;
  end

  // Chain positions: each picks its physical slot through the swap setting.
  for (genvar p = 0; p < NS; p++) begin : g_pos
    logic sel_p;
    logic act_p;
    assign sel_p = swap_q ^ 1'(p);
    assign act_p = cfg_oe[sel_p] & slot_present[sel_p];

    if (p == 0) begin : g_head
      assign chain_in[p] = in_q;
    end else begin : g_tail
      assign chain_in[p] = stage_q[p-1];
    end

    tsr_slot_stage u_stage (
      .clk        (clk),
      .rst_n      (rst_n),
      .chain_in   (chain_in[p]),
      .ret_in     (rx_beat[sel_p]),
      .use_module (act_p),
      .mask       (mask_arr[sel_p]),
      .q          (stage_q[p])
    );
  end

  tsr_hop_reg u_out_hop (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (stage_q[LAST]),
    .q     (out_q)
  );

  assign out_stb  = out_q.stb;
  assign out_vld  = out_q.vld;
  assign out_sync = out_q.sync;
  assign out_data = out_q.data;
endmodule

// File: rtl/tsr_router_chk.sv
module tsr_router_chk #(
  parameter int unsigned DW = 8,
  parameter int unsigned NS = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_stb,
  input logic           in_vld,
  input logic           in_sync,
  input logic [DW-1:0]  in_data,
  input logic [NS-1:0]  cfg_oe,
  input logic [NS-1:0]  slot_present,
  input logic [NS-1:0]  slot_tx_stb,
  input logic [NS-1:0]  slot_tx_vld,
  input logic [NS-1:0]  slot_tx_sync,
  input logic [NS*DW-1:0] slot_tx_data,
  input logic           out_stb,
  input logic           out_vld,
  input logic           out_sync,
  input logic [DW-1:0]  out_data,
  input logic           swap_q
);
  logic       started;
  logic [2:0] byp_run;
  logic       all_byp;

  assign all_byp = ~|(cfg_oe & slot_present);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      started <= 1'b0;
      byp_run <= '0;
    end else begin
      started <= 1'b1;
      if (!all_byp)          byp_run <= '0;
      else if (byp_run != 3'd7) byp_run <= byp_run + 3'd1;
    end
  end

  // R8
  empty_a_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_present[0] |-> (slot_tx_stb[0] == 1'b0 && slot_tx_vld[0] == 1'b0 &&
                          slot_tx_sync[0] == 1'b0 && slot_tx_data[DW-1:0] == '0));

  // R8
  empty_b_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_present[1] |-> (slot_tx_stb[1] == 1'b0 && slot_tx_data[2*DW-1:DW] == '0));

  // R7
  swap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_stb |=> $stable(swap_q));

  // R2
  bypass_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byp_run >= 3'd4) |-> (out_data == $past(in_data, 4) && out_sync == $past(in_sync, 4) &&
                           out_vld == $past(in_vld, 4) && out_stb == $past(in_stb, 4)));

  // R5
  head_feed_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started && slot_present[0] && !swap_q) |->
      (slot_tx_data[DW-1:0] == $past(in_data) && slot_tx_sync[0] == $past(in_sync)));

  // R5
  head_feed_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started && slot_present[1] && swap_q) |->
      (slot_tx_data[2*DW-1:DW] == $past(in_data) && slot_tx_stb[1] == $past(in_stb)));
endmodule

bind tsr_router tsr_router_chk #(.DW(tsr_pkg::TS_DATA_W), .NS(tsr_pkg::TS_SLOTS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_stb       (in_stb),
  .in_vld       (in_vld),
  .in_sync      (in_sync),
  .in_data      (in_data),
  .cfg_oe       (cfg_oe),
  .slot_present (slot_present),
  .slot_tx_stb  (slot_tx_stb),
  .slot_tx_vld  (slot_tx_vld),
  .slot_tx_sync (slot_tx_sync),
  .slot_tx_data (slot_tx_data),
  .out_stb      (out_stb),
  .out_vld      (out_vld),
  .out_sync     (out_sync),
  .out_data     (out_data),
  .swap_q       (swap_q)
);

// File: tb/sim_tsr_router.sv
module sim_tsr_router;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] INV_A = 8'h5A;
  localparam logic [7:0] INV_B = 8'hC3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_stb = 0, in_vld = 0, in_sync = 0;
  logic [7:0]  in_data = '0;
  logic        cfg_swap = 0;
  logic [1:0]  cfg_oe = '0;
  logic [15:0] cfg_mask = '0;
  logic [1:0]  slot_present = '0;
  logic [1:0]  slot_tx_stb, slot_tx_vld, slot_tx_sync;
  logic [15:0] slot_tx_data;
  logic [1:0]  slot_rx_stb, slot_rx_vld, slot_rx_sync;
  logic [15:0] slot_rx_data;
  logic        out_stb, out_vld, out_sync;
  logic [7:0]  out_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tsr_router u0 (
    .clk, .rst_n, .in_stb, .in_vld, .in_sync, .in_data,
    .cfg_swap, .cfg_oe, .cfg_mask, .slot_present,
    .slot_tx_stb, .slot_tx_vld, .slot_tx_sync, .slot_tx_data,
    .slot_rx_stb, .slot_rx_vld, .slot_rx_sync, .slot_rx_data,
    .out_stb, .out_vld, .out_sync, .out_data
  );

  // Module model: A adds 3, B rotates left; each then inverts with its own pattern.
  function automatic logic [7:0] mod_fn(int s, logic [7:0] d);
    if (s == 0) return (d + 8'd3) ^ INV_A;
    return {d[6:0], d[7]} ^ INV_B;
  endfunction

  function automatic logic [7:0] route(logic [7:0] d, logic sw, logic [1:0] oe,
                                       logic [1:0] pr, logic [15:0] mk);
    logic [7:0] v;
    v = d;
    for (int k = 0; k < 2; k++) begin
      int s;
      s = sw ? 1 - k : k;
      if (oe[s] && pr[s]) v = mod_fn(s, v) ^ mk[s*8 +: 8];
    end
    return v;
  endfunction

  always_comb begin
    slot_rx_stb  = slot_tx_stb;
    slot_rx_vld  = slot_tx_vld;
    slot_rx_sync = slot_tx_sync;
    for (int s = 0; s < 2; s++) slot_rx_data[s*8 +: 8] = mod_fn(s, slot_tx_data[s*8 +: 8]);
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Drive one strobed beat, then sample the output three edges after capture.
  task automatic beat_out(string tag, logic [7:0] d, logic v, logic sy, logic [7:0] exp);
    @(negedge clk);
    in_stb = 1; in_vld = v; in_sync = sy; in_data = d;
    @(posedge clk);
    @(negedge clk);
    in_stb = 0; in_vld = 0; in_sync = 0; in_data = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({tag, " data"}, 32'(out_data), 32'(exp));
    chk({tag, " flags"}, {29'd0, out_stb, out_vld, out_sync}, {29'd0, 1'b1, v, sy});
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 out after reset", {21'd0, out_stb, out_vld, out_sync, out_data}, 32'd0);
    chk("R1 tx after reset", {slot_tx_stb, slot_tx_data}, 32'd0);
    slot_present = 2'b11; cfg_oe = 2'b00;
    beat_out("R1 bypass default", 8'h47, 1, 1, 8'h47);
  endtask

  task automatic t_bypass;
    slot_present = 2'b11; cfg_oe = 2'b00; cfg_mask = 16'hFFFF;
    beat_out("R3 oe clear", 8'h00, 1, 0, 8'h00);
    beat_out("R9 oe clear", 8'hE1, 0, 1, 8'hE1);
    slot_present = 2'b00; cfg_oe = 2'b11;
    beat_out("R3 absent", 8'h9C, 1, 1, 8'h9C);
    cfg_mask = '0;
  endtask

  task automatic t_order;
    slot_present = 2'b11; cfg_oe = 2'b11; cfg_mask = {INV_B, INV_A};
    cfg_swap = 0;
    beat_out("R5 A then B", 8'h81, 1, 0, route(8'h81, 0, 2'b11, 2'b11, {INV_B, INV_A}));
    beat_out("R2 A then B", 8'hFE, 1, 1, route(8'hFE, 0, 2'b11, 2'b11, {INV_B, INV_A}));
    cfg_swap = 1;
    beat_out("R5 B then A", 8'h81, 1, 0, route(8'h81, 1, 2'b11, 2'b11, {INV_B, INV_A}));
    beat_out("R2 B then A", 8'hFE, 0, 1, route(8'hFE, 1, 2'b11, 2'b11, {INV_B, INV_A}));
    cfg_swap = 0;
  endtask

  task automatic t_invert;
    slot_present = 2'b11; cfg_oe = 2'b01; cfg_mask = 16'h0000;
    beat_out("R6 mask zero", 8'h10, 1, 1, route(8'h10, 0, 2'b01, 2'b11, 16'h0000));
    cfg_mask = {8'h00, INV_A};
    beat_out("R6 mask A", 8'h10, 1, 0, 8'h13);
    cfg_oe = 2'b10; cfg_mask = {8'h0F, 8'hFF};
    beat_out("R6 mask B", 8'h33, 1, 1, route(8'h33, 0, 2'b10, 2'b11, {8'h0F, 8'hFF}));
  endtask

  task automatic t_remove;
    logic [7:0] exp;
    slot_present = 2'b11; cfg_oe = 2'b11; cfg_mask = {INV_B, INV_A}; cfg_swap = 0;
    exp = route(8'h5C, 0, 2'b11, 2'b10, {INV_B, INV_A});
    @(negedge clk);
    in_stb = 1; in_vld = 1; in_sync = 0; in_data = 8'h5C;
    @(posedge clk);
    @(negedge clk);
    in_stb = 0; in_vld = 0; in_data = 8'h00;
    slot_present = 2'b10;  // card A pulled while its beat waits in front of it
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R4 pulled in flight", 32'(out_data), 32'(exp));
    beat_out("R4 stays bypassed", 8'h21, 1, 1, route(8'h21, 0, 2'b11, 2'b10, {INV_B, INV_A}));
    chk("R8 empty A tx", {24'd0, slot_tx_stb[0], slot_tx_vld[0], slot_tx_sync[0], 5'd0} |
                          32'(slot_tx_data[7:0]), 32'd0);
  endtask

  task automatic t_sample;
    slot_present = 2'b11; cfg_oe = 2'b00; cfg_swap = 0; cfg_mask = '0;
    beat_out("R7 load order", 8'h01, 1, 0, 8'h01);
    @(negedge clk);
    cfg_swap = 1; in_stb = 0; in_data = 8'hA5;
    @(posedge clk);
    @(negedge clk);
    chk("R7 swap ignored without strobe", 32'(slot_tx_data[7:0]), 32'hA5);
    in_stb = 1; in_data = 8'h3C;
    @(posedge clk);
    @(negedge clk);
    chk("R7 swap taken on strobe", 32'(slot_tx_data[15:8]), 32'h3C);
    in_stb = 0;
    // Mask change without strobe must not reach data.
    cfg_swap = 0; cfg_oe = 2'b01;
    beat_out("R7 load mask", 8'h02, 1, 0, route(8'h02, 0, 2'b01, 2'b11, 16'h0000));
    @(negedge clk);
    cfg_mask = 16'h00FF; in_stb = 0; in_vld = 1; in_data = 8'h11;
    @(posedge clk);
    @(negedge clk);
    in_vld = 0; in_data = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R7 mask ignored without strobe", 32'(out_data), 32'(route(8'h11, 0, 2'b01, 2'b11, 16'h0000)));
    chk("R9 unstrobed beat flags", {30'd0, out_stb, out_vld}, 32'd1);
    cfg_mask = '0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    t_reset();
    t_bypass();
    t_order();
    t_invert();
    t_remove();
    t_sample();
    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule